// File: doc/BRIEF.md
# Nine-bit FIFO with retransmit and shared half-full / expansion flag

This block is a first-in/first-out buffer for 9-bit words, so each byte can carry a parity or control bit. All of its inputs are sampled on one clock. The write and read strobes are active low, and the block acts on their falling edges. No address is needed: storage is walked by write and read pointers that wrap from the last location back to zero. The depth is a parameter, one of 256, 512, 1024, 2048, 4096 or 8192 words. A write and a read may fall in the same cycle, and each takes effect independently of the other.

Three active-low flags give the state of the buffer: empty, full, and a shared flag. In single-device mode the shared flag reports half-full. In expansion mode it gives a one-cycle pulse whenever a pointer passes the last location. The retransmit input is active only in single-device mode. It rewinds the read pointer to location zero, so the data written since reset can be read again. Read data is presented with an output-enable that stays high for as long as an accepted read strobe is held low.

Top module: `fifo9_rt`

## Requirements
- R1: After reset, empty_n is 0, full_n is 1, hf_xo_n is 1 and dout_oe is 0.
- R2: A falling edge of wr_n stores din. Words leave in the order they were written, including after either pointer wraps past the last location.
- R3: A falling edge of rd_n on a non-empty buffer presents the oldest word on dout. dout_oe is 1 from the following clock edge until rd_n is sampled high.
- R4: empty_n is 0 exactly when the stored count is zero. It is updated at the clock edge that changes the count.
- R5: full_n is 0 exactly when the stored count equals DEPTH.
- R6: In single mode (single_mode = 1), hf_xo_n is 0 exactly when the count is greater than DEPTH/2.
- R7: A write strobe while the buffer is full is ignored. No word is stored or lost.
- R8: A read strobe while the buffer is empty is ignored. dout_oe stays 0 and dout keeps its last value.
- R9: A write and a read accepted at the same clock edge leave the count unchanged, and each of them completes.
- R10: In single mode, a falling edge of rt_n does three things: it sets the read pointer to 0, it reloads the count to the number of words written since reset (capped at DEPTH), and it leaves the write pointer untouched. A read strobe at that same edge is ignored.
- R11: In expansion mode (single_mode = 0), hf_xo_n pulses 0 for one cycle after a write into the last location or a read from the last location. rt_n has no effect in this mode.
- R12: Each strobe acts once per falling edge. Holding it low for several cycles gives a single operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| single_mode | input | 1 | 1 = single-device mode (half-full flag, retransmit); 0 = expansion mode |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit strobe |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data |
| dout_oe | output | 1 | Read data valid / output enable |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |
| hf_xo_n | output | 1 | Half-full flag (single mode) or expansion-out pulse |

## Verification
The bench derives every expected flag from an arithmetic word count and every expected word from a formula of its write index. A miscounted occupancy therefore shows on empty_n, full_n or hf_xo_n at the first edge where the count crosses a threshold. A pointer that slips or wraps badly shows as a wrong word on the very next read. A faulty rewind shows up in two ways: the replay does not restart at the first word, or empty_n settles after the wrong number of reads. Both appear within one transfer of the fault.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

  typedef struct packed {
    logic rt;
    logic rd;
    logic wr;
  } strobe_ev_t;

  localparam int unsigned STROBE_N = 3;

endpackage

// File: rtl/fifo9_edge.sv
module fifo9_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    logic prev_d;

    always_comb begin
      prev_d = strobe_n[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= prev_d;
    end

    assign fall[i] = prev_q & ~strobe_n[i];
  end

endmodule

// File: rtl/fifo9_ctrl.sv
module fifo9_ctrl
  import fifo9_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_mode,
  input  strobe_ev_t    ev,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count_d,
  output logic          xo_ev
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] count_q, written_q, written_d;
  logic          rt_ok;

  always_comb begin
    rt_ok  = ev.rt & single_mode;
    wr_ok  = ev.wr & (count_q != FULLC);
    rd_ok  = ev.rd & (count_q != '0) & ~rt_ok;

    wptr_d = wptr_q;
    if (wr_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;

    written_d = written_q;
    if (wr_ok && written_q != FULLC) written_d = written_q + 1'b1;

    rptr_d = rptr_q;
    if (rt_ok)      rptr_d = '0;
    else if (rd_ok) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;

    if (rt_ok) count_d = written_d;
    else       count_d = count_q + {{AW{1'b0}}, wr_ok} - {{AW{1'b0}}, rd_ok};

    xo_ev = (wr_ok & (wptr_q == LAST)) | (rd_ok & (rptr_q == LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      count_q   <= '0;
      written_q <= '0;
    end else begin
      wptr_q    <= wptr_d;
      rptr_q    <= rptr_d;
      count_q   <= count_d;
      written_q <= written_d;
    end
  end

  assign wptr = wptr_q;
  assign rptr = rptr_q;

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULLC);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.wr && count_q == FULLC) |=> $stable(wptr_q));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rd && count_q == '0 && !rt_ok) |=> $stable(rptr_q));
  assert_rewind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rt_ok |=> (rptr_q == '0 && $stable(wptr_q)));

endmodule

// File: rtl/fifo9_store.sv
module fifo9_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic             rd_ok,
  input  logic             rd_low,
  input  logic [AW-1:0]    wptr,
  input  logic [AW-1:0]    rptr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] dout_q;
  logic             oe_q, oe_d;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_comb begin
    oe_d = rd_ok | (oe_q & rd_low);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (rd_ok) dout_q <= mem[rptr];
      oe_q <= oe_d;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;

  assert_oe_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_q && !rd_ok) |=> !oe_q);
  assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(dout_q));

endmodule

// File: rtl/fifo9_flags.sv
module fifo9_flags #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_mode,
  input  logic [CW-1:0] count_d,
  input  logic          xo_ev,
  output logic          empty_n,
  output logic          full_n,
  output logic          hf_xo_n
);

  localparam logic [CW-1:0] HALF  = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic empty_d, full_d, hf_d;
  logic empty_q, full_q, hf_q;

  always_comb begin
    empty_d = (count_d != '0);
    full_d  = (count_d != FULLC);
    hf_d    = single_mode ? ~(count_d > HALF) : ~xo_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      full_q  <= 1'b1;
      hf_q    <= 1'b1;
    end else begin
      empty_q <= empty_d;
      full_q  <= full_d;
      hf_q    <= hf_d;
    end
  end

  assign empty_n = empty_q;
  assign full_n  = full_q;
  assign hf_xo_n = hf_q;

  assert_flag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_q && !full_q));
  assert_hf_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && !hf_q) |-> empty_q);

endmodule

// File: rtl/fifo9_rt.sv
module fifo9_rt
  import fifo9_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_mode,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty_n,
  output logic             full_n,
  output logic             hf_xo_n
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [STROBE_N-1:0] fall;
  strobe_ev_t          ev;
  logic                wr_ok, rd_ok, xo_ev;
  logic [AW-1:0]       wptr, rptr;
  logic [CW-1:0]       count_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fifo9_edge #(.N(STROBE_N)) u_edge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_n ({rt_n, rd_n, wr_n}),
    .fall     (fall)
  );

  assign ev = strobe_ev_t'(fall);

  fifo9_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .single_mode (single_mode),
    .ev          (ev),
    .wr_ok       (wr_ok),
    .rd_ok       (rd_ok),
    .wptr        (wptr),
    .rptr        (rptr),
    .count_d     (count_d),
    .xo_ev       (xo_ev)
  );

  fifo9_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .rd_low  (~rd_n),
    .wptr    (wptr),
    .rptr    (rptr),
    .din     (din),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

  fifo9_flags #(.DEPTH(DEPTH)) u_flags (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .single_mode (single_mode),
    .count_d     (count_d),
    .xo_ev       (xo_ev),
    .empty_n     (empty_n),
    .full_n      (full_n),
    .hf_xo_n     (hf_xo_n)
  );

  assert_single_op_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_ok |=> !wr_ok);

endmodule

// File: tb/sim_fifo9_rt.sv
`timescale 1ns/1ps
module sim_fifo9_rt;

  localparam int DEPTH = 256;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rst_n, single_mode, wr_n, rd_n, rt_n;
  logic [8:0] din;
  logic [8:0] dout;
  logic       dout_oe, empty_n, full_n, hf_xo_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fifo9_rt #(.DEPTH(DEPTH), .WIDTH(9)) u0 (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode),
    .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n),
    .full_n(full_n), .hf_xo_n(hf_xo_n)
  );

  function automatic logic [8:0] v(input int i);
    return 9'((i * 7 + 3) % 512);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; single_mode = mode;
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge clk); din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic rd(output logic [8:0] q, output logic oe);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); q = dout; oe = dout_oe; rd_n = 1'b1;
  endtask

  task automatic pulse_rt();
    @(negedge clk); rt_n = 1'b0;
    @(negedge clk); rt_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] q;
    logic       oe;
    int         cnt;

    // R1 reset state
    do_reset(1'b1);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 hf_xo_n", hf_xo_n, 1);
    chk("R1 dout_oe", dout_oe, 0);

    // fill: R4 R5 R6
    for (int i = 1; i <= DEPTH; i++) begin
      wr(v(i - 1));
      chk("R4 empty_n fill", empty_n, 1);
      chk("R5 full_n fill", full_n, (i == DEPTH) ? 0 : 1);
      chk("R6 hf fill", hf_xo_n, (i > HALF) ? 0 : 1);
    end

    // R7 write while full ignored
    wr(9'h1AA);
    chk("R7 full_n stays", full_n, 0);

    // drain: R2 R3 R4 R5 R6
    for (int j = 0; j < DEPTH; j++) begin
      rd(q, oe);
      cnt = DEPTH - 1 - j;
      chk("R2 data order", q, v(j));
      chk("R3 oe", oe, 1);
      chk("R4 empty_n drain", empty_n, (cnt == 0) ? 0 : 1);
      chk("R5 full_n drain", full_n, 1);
      chk("R6 hf drain", hf_xo_n, (cnt > HALF) ? 0 : 1);
    end
    @(negedge clk);
    chk("R3 oe drops", dout_oe, 0);

    // R8 read while empty
    rd(q, oe);
    chk("R8 oe stays low", oe, 0);
    chk("R8 dout held", q, v(DEPTH - 1));
    chk("R8 empty_n", empty_n, 0);

    // R2 after wrap
    for (int i = DEPTH; i < DEPTH + 5; i++) begin
      wr(v(i));
      rd(q, oe);
      chk("R2 wrap data", q, v(i));
    end

    // R9 simultaneous
    wr(v(300));
    @(negedge clk); din = v(301); wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk("R9 read data", dout, v(300));
    chk("R9 empty_n", empty_n, 1);
    wr_n = 1'b1; rd_n = 1'b1;
    rd(q, oe);
    chk("R9 written data", q, v(301));
    chk("R9 empty after", empty_n, 0);

    // R12 held strobe
    @(negedge clk); din = v(400); wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1;
    rd(q, oe);
    chk("R12 one word", q, v(400));
    rd(q, oe);
    chk("R12 no second word", oe, 0);

    // R10 retransmit
    do_reset(1'b1);
    for (int i = 0; i < 10; i++) wr(v(500 + i));
    for (int i = 0; i < 4; i++) begin
      rd(q, oe);
      chk("R10 pre read", q, v(500 + i));
    end
    pulse_rt();
    @(negedge clk);
    chk("R10 empty_n after rewind", empty_n, 1);
    for (int i = 0; i < 10; i++) begin
      rd(q, oe);
      chk("R10 replay data", q, v(500 + i));
      chk("R10 replay empty_n", empty_n, (i == 9) ? 0 : 1);
    end
    wr(v(600));
    rd(q, oe);
    chk("R10 write pointer kept", q, v(600));

    // R11 expansion mode
    do_reset(1'b0);
    for (int i = 1; i <= DEPTH; i++) begin
      wr(v(i));
      chk("R11 xo on write", hf_xo_n, (i == DEPTH) ? 0 : 1);
    end
    @(negedge clk);
    chk("R11 xo one cycle", hf_xo_n, 1);
    chk("R5 full in expansion", full_n, 0);
    for (int j = 0; j < DEPTH; j++) begin
      rd(q, oe);
      chk("R11 xo on read", hf_xo_n, (j == DEPTH - 1) ? 0 : 1);
    end
    @(negedge clk);
    chk("R11 xo release", hf_xo_n, 1);
    pulse_rt();
    @(negedge clk);
    chk("R11 rt ignored empty_n", empty_n, 0);
    rd(q, oe);
    chk("R11 rt ignored read", oe, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule